// File: doc/BRIEF.md
# Calendar Counters with Increment Interrupts

This block keeps the time-of-day and date for a real-time clock. Eight counters hold the second, minute, hour, day of month, day of week, day of year, month and a 12-bit year. A one-second strobe advances the seconds. Each counter that wraps passes a carry to the next counter in the same clock cycle, so a single strobe can move every field at once, for example at midnight on the last day of the year.

An eight-bit mask chooses which field increments raise the interrupt line. The interrupt is sticky. Software clears it with a write strobe that carries a 1 in bit 0. While the enable input is low, the counters stop and each one can be preloaded through a small select/data write port. While the enable is high, that port is ignored.

Month lengths come from a fixed table. February has 29 days when the two low year bits are 00. The same rule sets the day-of-year limit: 366 in such years and 365 otherwise.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous reset the outputs are: seconds 0, minutes 0, hours 0, day of month 1, day of week 0, day of year 1, month 1, year 0, interrupt 0.
- R2: While `run_en` is 1, each cycle with `tick_1hz` high adds one to the seconds. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and produce a day carry. All of this happens in the same cycle as the strobe.
- R3: A day carry advances day of month, day of week and day of year together. Day of week wraps from 6 to 0.
- R4: Day of month wraps to 1 after the last day of the month. The month lengths are 31 for months 1, 3, 5, 7, 8, 10 and 12; 30 for months 4, 6, 9 and 11; and for month 2, 29 when year[1:0] is 00 and 28 otherwise. That wrap advances the month. Month wraps from 12 to 1 and advances the year, and the year wraps from 4095 to 0.
- R5: Day of year wraps to 1 after 366 when year[1:0] is 00, and after 365 otherwise.
- R6: While `run_en` is 0, the strobe has no effect and every counter holds its value unless it is written.
- R7: When `wr_en` is 1 and `run_en` is 0, the low bits of `wr_data` load the field chosen by `wr_sel`. The select codes are: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year. While `run_en` is 1, writes have no effect.
- R8: Mask bit order from bit 0 upward: seconds, minutes, hours, day of month, day of week, day of year, month, year. When a field advances (wrapping counts as advancing) and its mask bit is 1, `irq_o` is 1 from the next cycle.
- R9: `irq_o` stays 1 until a cycle with `ack_we` and `ack_bit0` both 1. After that cycle it reads 0. An acknowledge with `ack_bit0` at 0 has no effect.
- R10: If a masked increment and a valid acknowledge occur in the same cycle, `irq_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second strobe, one cycle wide |
| run_en | input | 1 | Counter enable; 0 stops the counters and opens the write port |
| wr_en | input | 1 | Preload write strobe |
| wr_sel | input | 3 | Field select for the preload write |
| wr_data | input | 12 | Preload value; only the low bits that fit the field are used |
| inc_mask | input | 8 | Per-field increment-interrupt mask |
| ack_we | input | 1 | Interrupt acknowledge write strobe |
| ack_bit0 | input | 1 | Bit 0 of the acknowledge write; a 1 clears the interrupt |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hours |
| mday_o | output | 5 | Day of month |
| wday_o | output | 3 | Day of week |
| yday_o | output | 9 | Day of year |
| month_o | output | 4 | Month |
| year_o | output | 12 | Year |
| irq_o | output | 1 | Sticky increment interrupt |

## Verification
Every field is visible at a port, so a wrong count or a missing carry shows on the cycle right after the strobe that should have caused it. A broken month or leap table shows only on the strobe that crosses a month or year end. The bench therefore preloads the last second before each such boundary instead of waiting for it to arrive. A mask or latch fault shows on `irq_o` one cycle after the event or the acknowledge. The bench's behavioural model compares all nine outputs on every clock.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int MDAY_W = 5;
    localparam int WDAY_W = 3;
    localparam int YDAY_W = 9;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 12;
    localparam int NFIELD = 8;
    localparam int DATA_W = YEAR_W;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_MDAY = 3'd3,
        F_WDAY = 3'd4,
        F_YDAY = 3'd5,
        F_MON  = 3'd6,
        F_YEAR = 3'd7
    } field_e;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [YDAY_W-1:0] yday;
        logic [WDAY_W-1:0] wday;
        logic [MDAY_W-1:0] mday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    function automatic logic is_leap(input logic [YEAR_W-1:0] yr);
        return (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [MDAY_W-1:0] month_days(input logic [MON_W-1:0] m,
                                                     input logic leap);
        case (m)
            4'd2:                   return leap ? MDAY_W'(29) : MDAY_W'(28);
            4'd4, 4'd6, 4'd9, 4'd11: return MDAY_W'(30);
            default:                return MDAY_W'(31);
        endcase
    endfunction

    function automatic logic [YDAY_W-1:0] year_days(input logic leap);
        return leap ? YDAY_W'(366) : YDAY_W'(365);
    endfunction

endpackage

// File: rtl/rtc_field_ctr.sv
module rtc_field_ctr #(
    parameter int W  = 6,
    parameter int LO = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic [W-1:0] top_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] val_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LO_V = W'(LO);

    logic [W-1:0] val_q;

    assign wrap_o = inc_i && (val_q == top_i);
    assign val_o  = val_q;

    always_ff @(posedge clk) begin
        if (rst)
            val_q <= LO_V;
        else if (wr_i)
            val_q <= wdata_i;
        else if (inc_i)
            val_q <= wrap_o ? LO_V : val_q + 1'b1;
    end

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        inc_i && !wr_i && (val_q != top_i) |=> val_q == W'($past(val_q) + 1'b1));

    // R4
    wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
        inc_i && !wr_i && (val_q == top_i) |=> val_q == LO_V);

    // R7
    load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> val_q == $past(wdata_i));

endmodule

// File: rtl/rtc_irq_latch.sv
module rtc_irq_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] event_i,
    input  logic [N-1:0] mask_i,
    input  logic         clr_i,
    output logic         irq_o
);
    logic irq_q;
    logic hit;

    assign hit   = |(event_i & mask_i);
    assign irq_o = irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (hit)
            irq_q <= 1'b1;
        else if (clr_i)
            irq_q <= 1'b0;
    end

    // R8
    masked_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq_q);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q && !clr_i |=> irq_q);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i && !hit |=> !irq_q);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_q && !hit |=> !irq_q);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              run_en,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NFIELD-1:0] inc_mask,
    input  logic              ack_we,
    input  logic              ack_bit0,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic [MDAY_W-1:0] mday_o,
    output logic [WDAY_W-1:0] wday_o,
    output logic [YDAY_W-1:0] yday_o,
    output logic [MON_W-1:0]  month_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              irq_o
);
    cal_t              cal;
    logic [NFIELD-1:0] fld_we;
    logic [NFIELD-1:0] adv;
    logic              sec_wrap, min_wrap, hour_wrap, mday_wrap, mon_wrap;
    logic              wday_wrap, yday_wrap, year_wrap;
    logic              leap;
    logic              step;

    assign step = run_en && tick_1hz;
    assign leap = is_leap(cal.year);

    for (genvar k = 0; k < NFIELD; k++) begin : g_we
        assign fld_we[k] = wr_en && !run_en && (wr_sel == 3'(k));
    end

    // carry ripple within one cycle
    assign adv[F_SEC]  = step;
    assign adv[F_MIN]  = sec_wrap;
    assign adv[F_HOUR] = min_wrap;
    assign adv[F_MDAY] = hour_wrap;
    assign adv[F_WDAY] = hour_wrap;
    assign adv[F_YDAY] = hour_wrap;
    assign adv[F_MON]  = mday_wrap;
    assign adv[F_YEAR] = mon_wrap;

    rtc_field_ctr #(.W(SEC_W), .LO(0)) u_sec (
        .clk(clk), .rst(rst), .inc_i(adv[F_SEC]), .top_i(SEC_W'(59)),
        .wr_i(fld_we[F_SEC]), .wdata_i(wr_data[SEC_W-1:0]),
        .val_o(cal.sec), .wrap_o(sec_wrap));

    rtc_field_ctr #(.W(MIN_W), .LO(0)) u_min (
        .clk(clk), .rst(rst), .inc_i(adv[F_MIN]), .top_i(MIN_W'(59)),
        .wr_i(fld_we[F_MIN]), .wdata_i(wr_data[MIN_W-1:0]),
        .val_o(cal.min), .wrap_o(min_wrap));

    rtc_field_ctr #(.W(HOUR_W), .LO(0)) u_hour (
        .clk(clk), .rst(rst), .inc_i(adv[F_HOUR]), .top_i(HOUR_W'(23)),
        .wr_i(fld_we[F_HOUR]), .wdata_i(wr_data[HOUR_W-1:0]),
        .val_o(cal.hour), .wrap_o(hour_wrap));

    rtc_field_ctr #(.W(MDAY_W), .LO(1)) u_mday (
        .clk(clk), .rst(rst), .inc_i(adv[F_MDAY]), .top_i(month_days(cal.mon, leap)),
        .wr_i(fld_we[F_MDAY]), .wdata_i(wr_data[MDAY_W-1:0]),
        .val_o(cal.mday), .wrap_o(mday_wrap));

    rtc_field_ctr #(.W(WDAY_W), .LO(0)) u_wday (
        .clk(clk), .rst(rst), .inc_i(adv[F_WDAY]), .top_i(WDAY_W'(6)),
        .wr_i(fld_we[F_WDAY]), .wdata_i(wr_data[WDAY_W-1:0]),
        .val_o(cal.wday), .wrap_o(wday_wrap));

    rtc_field_ctr #(.W(YDAY_W), .LO(1)) u_yday (
        .clk(clk), .rst(rst), .inc_i(adv[F_YDAY]), .top_i(year_days(leap)),
        .wr_i(fld_we[F_YDAY]), .wdata_i(wr_data[YDAY_W-1:0]),
        .val_o(cal.yday), .wrap_o(yday_wrap));

    rtc_field_ctr #(.W(MON_W), .LO(1)) u_mon (
        .clk(clk), .rst(rst), .inc_i(adv[F_MON]), .top_i(MON_W'(12)),
        .wr_i(fld_we[F_MON]), .wdata_i(wr_data[MON_W-1:0]),
        .val_o(cal.mon), .wrap_o(mon_wrap));

    rtc_field_ctr #(.W(YEAR_W), .LO(0)) u_year (
        .clk(clk), .rst(rst), .inc_i(adv[F_YEAR]), .top_i({YEAR_W{1'b1}}),
        .wr_i(fld_we[F_YEAR]), .wdata_i(wr_data[YEAR_W-1:0]),
        .val_o(cal.year), .wrap_o(year_wrap));

    rtc_irq_latch #(.N(NFIELD)) u_irq (
        .clk(clk), .rst(rst), .event_i(adv), .mask_i(inc_mask),
        .clr_i(ack_we && ack_bit0), .irq_o(irq_o));

    assign sec_o   = cal.sec;
    assign min_o   = cal.min;
    assign hour_o  = cal.hour;
    assign mday_o  = cal.mday;
    assign wday_o  = cal.wday;
    assign yday_o  = cal.yday;
    assign month_o = cal.mon;
    assign year_o  = cal.year;

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en && !wr_en |=> $stable(cal));

    // R7
    run_wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        run_en && wr_en && !tick_1hz |=> $stable(cal));

    // R3
    day_together_chk: assert property (@(posedge clk) disable iff (rst)
        hour_wrap |=> (cal.hour == '0) && ($past(cal.wday) == 3'd6 ? cal.wday == '0
                                          : cal.wday == $past(cal.wday) + 1'b1));

    // R5
    yday_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        yday_wrap |=> cal.yday == YDAY_W'(1));

    // R2
    single_event_chk: assert property (@(posedge clk) disable iff (rst)
        !step |-> adv == '0);

    logic unused_wraps;
    assign unused_wraps = wday_wrap ^ year_wrap;

endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0, run_en = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic [7:0]  inc_mask = '0;
    logic        ack_we = 1'b0, ack_bit0 = 1'b0;
    logic [5:0]  sec_o, min_o;
    logic [4:0]  hour_o, mday_o;
    logic [2:0]  wday_o;
    logic [8:0]  yday_o;
    logic [3:0]  month_o;
    logic [11:0] year_o;
    logic        irq_o;

    always #5ns clk = ~clk;

    rtc_calendar_core u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .run_en(run_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .inc_mask(inc_mask),
        .ack_we(ack_we), .ack_bit0(ack_bit0),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mday_o(mday_o),
        .wday_o(wday_o), .yday_o(yday_o), .month_o(month_o), .year_o(year_o),
        .irq_o(irq_o));

    int n_chk = 0, n_bad = 0;
    bit cmp_on = 0;
    bit done = 0;

    // behavioural reference state
    int m_s, m_mi, m_h, m_md, m_wd, m_yd, m_mo, m_y;
    bit m_irq;

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        return 30 + ((mo + mo / 8) % 2);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0d expected %0d", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit [7:0] ev;
        ev = '0;
        if (rst) begin
            m_s = 0; m_mi = 0; m_h = 0; m_md = 1; m_wd = 0; m_yd = 1; m_mo = 1; m_y = 0;
            m_irq = 0;
        end else begin
            if (!run_en && wr_en) begin
                case (wr_sel)
                    3'd0: m_s  = wr_data % 64;
                    3'd1: m_mi = wr_data % 64;
                    3'd2: m_h  = wr_data % 32;
                    3'd3: m_md = wr_data % 32;
                    3'd4: m_wd = wr_data % 8;
                    3'd5: m_yd = wr_data % 512;
                    3'd6: m_mo = wr_data % 16;
                    default: m_y = wr_data;
                endcase
            end
            if (run_en && tick_1hz) begin
                ev[0] = 1; m_s++;
                if (m_s == 60) begin
                    m_s = 0; ev[1] = 1; m_mi++;
                    if (m_mi == 60) begin
                        m_mi = 0; ev[2] = 1; m_h++;
                        if (m_h == 24) begin
                            m_h = 0; ev[3] = 1; ev[4] = 1; ev[5] = 1;
                            m_wd = (m_wd + 1) % 7;
                            m_yd++;
                            if (m_yd > ((m_y % 4 == 0) ? 366 : 365)) m_yd = 1;
                            m_md++;
                            if (m_md > mlen(m_mo, m_y)) begin
                                m_md = 1; ev[6] = 1; m_mo++;
                                if (m_mo > 12) begin
                                    m_mo = 1; ev[7] = 1; m_y = (m_y + 1) % 4096;
                                end
                            end
                        end
                    end
                end
            end
            if ((ev & inc_mask) != 0) m_irq = 1;
            else if (ack_we && ack_bit0) m_irq = 0;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R2 sec",  sec_o,   m_s);
            chk("R2 min",  min_o,   m_mi);
            chk("R2 hour", hour_o,  m_h);
            chk("R4 mday", mday_o,  m_md);
            chk("R3 wday", wday_o,  m_wd);
            chk("R5 yday", yday_o,  m_yd);
            chk("R4 month", month_o, m_mo);
            chk("R4 year", year_o,  m_y);
            chk("R8 irq",  irq_o,   m_irq);
        end
    end

    task automatic idle();
        tick_1hz = 0; wr_en = 0; ack_we = 0; ack_bit0 = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle();
    endtask

    task automatic wr(int sel, int val);
        run_en = 0; wr_en = 1; wr_sel = 3'(sel); wr_data = 12'(val);
        cyc();
    endtask

    task automatic load(int s, int mi, int h, int md, int wd, int yd, int mo, int y);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, md); wr(4, wd); wr(5, yd); wr(6, mo); wr(7, y);
    endtask

    task automatic tick();
        run_en = 1; tick_1hz = 1;
        cyc();
    endtask

    task automatic ack(bit b0);
        ack_we = 1; ack_bit0 = b0;
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sec", sec_o, 0); chk("R1 mday", mday_o, 1); chk("R1 yday", yday_o, 1);
        chk("R1 month", month_o, 1); chk("R1 year", year_o, 0); chk("R1 irq", irq_o, 0);

        inc_mask = 8'hFF;
        // R5 non-leap year end
        load(50, 59, 23, 31, 6, 365, 12, 3);
        repeat (15) tick();
        chk("R5 yday after 365", yday_o, 1);
        chk("R4 year advance", year_o, 4);
        ack(1);
        // R4 leap February
        load(59, 59, 23, 28, 2, 59, 2, 4); tick();
        chk("R4 feb29", mday_o, 29);
        load(59, 59, 23, 29, 3, 60, 2, 4); tick();
        chk("R4 mar1 leap", month_o, 3); chk("R3 yday 61", yday_o, 61);
        load(59, 59, 23, 31, 0, 366, 12, 4); tick();
        chk("R5 yday after 366", yday_o, 1);
        load(59, 59, 23, 28, 0, 59, 2, 5); tick();
        chk("R4 feb28 nonleap", month_o, 3);
        load(59, 59, 23, 31, 1, 365, 12, 4095); tick();
        chk("R4 year wrap", year_o, 0);
        load(59, 59, 23, 30, 6, 120, 4, 9); tick();
        chk("R4 30-day month", mday_o, 1); chk("R3 wday wrap", wday_o, 0);

        // R6 strobe ignored while stopped
        run_en = 0;
        repeat (5) begin tick_1hz = 1; run_en = 0; cyc(); end
        chk("R6 hold sec", sec_o, 0);

        // R7 writes ignored while running
        run_en = 1; wr_en = 1; wr_sel = 3'd2; wr_data = 12'd7; cyc();
        chk("R7 run write ignored", hour_o, 0);
        wr(2, 7);
        chk("R7 stopped write", hour_o, 7);

        // R9 sticky and ack bit0
        inc_mask = 8'h01; ack(1);
        tick(); chk("R9 set", irq_o, 1);
        run_en = 1; repeat (3) cyc(); chk("R9 sticky", irq_o, 1);
        ack(0); chk("R9 ack bit0=0 ignored", irq_o, 1);
        ack(1); chk("R9 cleared", irq_o, 0);

        // R10 set beats clear
        tick(); run_en = 1; tick_1hz = 1; ack_we = 1; ack_bit0 = 1; cyc();
        chk("R10 set wins", irq_o, 1);
        ack(1);

        // R8 single mask bit: month only
        inc_mask = 8'h40;
        load(58, 59, 23, 31, 2, 31, 1, 7); tick();
        chk("R8 no month event", irq_o, 0);
        tick(); chk("R8 month event", irq_o, 1);
        ack(1);

        // random traffic
        for (int i = 0; i < 30000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 3) begin
                wr($urandom % 3, 55 + ($urandom % 5) - (($urandom % 3 == 2) ? 0 : 0));
                if ($urandom % 2 == 0) wr(2, 23);
            end else begin
                run_en = ($urandom % 16) != 0;
                tick_1hz = ($urandom % 2) == 0;
                inc_mask = 8'($urandom);
                ack_we = ($urandom % 4) == 0;
                ack_bit0 = ($urandom % 2) == 0;
                wr_en = ($urandom % 8) == 0;
                wr_sel = 3'd0; wr_data = 12'd30;
                cyc();
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule